// File: doc/BRIEF.md
# Weak-Bit Protected ROM Read Stage

This block sits between a CPU and a cartridge program ROM and imitates EPROM areas whose cells read back unstable. Reads in two 128-byte address windows do not return ROM contents. They return a fixed byte whose three lowest bits come from a pseudo-random generator. Reads at any other address return the ROM byte unchanged. The read data path is combinational from the address. The generator state is the only storage in the block.

The generator is a 32-bit xorshift register. It takes a seed while reset is asserted and steps once for each strobed read inside a window. A zero seed would lock the generator, so a fixed nonzero constant replaces it. The full state is visible on an output port and can be written through a load port. A saved machine state can therefore be restored, and it then yields exactly the same sequence of unstable bits. A load in the same cycle as a protected read wins over the step.

Top module: `weak_rom_read`

## Requirements
- R1: Addresses 0xCE80 to 0xCEFF inclusive form protected window 0. 0xCE7F and 0xCF00 are not protected.
- R2: Addresses 0xFE80 to 0xFEFF inclusive form protected window 1. 0xFE7F is not protected.
- R3: For a protected address, `rd_data` bits 7..3 are 5'b11110 (the upper bits of 0xF2), and bits 2..0 equal `st_out[2:0]` as the state stands before that read's step.
- R4: For an address outside both windows, `rd_data` equals `rom_data`, and the generator state does not change.
- R5: At a rising edge where `rd_en` is 1 and the address is protected, the state s becomes t3, where t1 = s ^ (s<<13), t2 = t1 ^ (t1>>17) and t3 = t2 ^ (t2<<5), all on 32 bits. The new state shows on `st_out` after that edge.
- R6: While `rst_n` is 0, the state takes `seed_in`. A zero seed is replaced by 0x1D872B41.
- R7: At a rising edge with `st_load` high, the state takes `st_load_val`. A zero value is replaced by 0x1D872B41. Restoring a saved state reproduces the same read data sequence.
- R8: When `st_load` and a strobed protected read fall on the same edge, the load value is taken and no step is applied.
- R9: With `rd_en` low, a protected address still yields the pattern byte, but the state does not step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; loads the seed |
| cpu_addr | input | 16 | CPU read address |
| rd_en | input | 1 | Read strobe; steps the generator on protected reads |
| rom_data | input | 8 | Byte from the ROM storage |
| seed_in | input | 32 | Power-on seed |
| st_load | input | 1 | Load the generator state from `st_load_val` |
| st_load_val | input | 32 | State value to restore |
| st_out | output | 32 | Current generator state, for saving |
| rd_data | output | 8 | Read data returned to the CPU |

## Verification
The two functions that can coincide are a state restore and a generator step caused by a strobed protected read. The bench raises `st_load` while `rd_en` is high on an address inside window 1. After the edge it expects `st_out` to hold the loaded value, not its xorshift successor. A second case loads zero during a protected read and expects the substitute constant. That confirms the zero guard also applies when the load takes priority.

// File: rtl/wbr_pkg.sv
package wbr_pkg;

    localparam int unsigned STATE_W = 32;

    localparam logic [STATE_W-1:0] ZERO_SUB = 32'h1D87_2B41;

    typedef logic [STATE_W-1:0] prng_state_t;

    function automatic prng_state_t xs_step(input prng_state_t s);
        prng_state_t t;
        t = s;
        t = t ^ (t << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    function automatic prng_state_t nz_fix(input prng_state_t s);
        return (s == '0) ? ZERO_SUB : s;
    endfunction

endpackage

// File: rtl/wbr_window_match.sv
module wbr_window_match #(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned NUM_WIN  = 2,
    parameter int unsigned WIN_SIZE = 128,
    parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_BASE = {16'hFE80, 16'hCE80}
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int unsigned OFF_W = $clog2(WIN_SIZE);

    logic [NUM_WIN-1:0] win_hit;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        assign win_hit[w] = (addr[ADDR_W-1:OFF_W] == WIN_BASE[w][ADDR_W-1:OFF_W]);
    end

    assign hit = |win_hit;

    always_comb begin
        assert ($onehot0(win_hit)); // R1 R2: windows never overlap
    end

endmodule

// File: rtl/wbr_prng_state.sv
module wbr_prng_state
    import wbr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  prng_state_t seed,
    input  logic        adv,
    input  logic        ld_en,
    input  prng_state_t ld_val,
    output prng_state_t state
);
    typedef struct packed {
        prng_state_t st;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (ld_en) begin
            r_d.st = nz_fix(ld_val);
        end else if (adv) begin
            r_d.st = xs_step(r_q.st);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st <= nz_fix(seed);
        end else begin
            r_q <= r_d;
        end
    end

    assign state = r_q.st;

    assert_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st != '0);

    assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !adv) |=> (state == (($past(ld_val) == '0) ? ZERO_SUB : $past(ld_val))));

    assert_load_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && adv) |=> (state == (($past(ld_val) == '0) ? ZERO_SUB : $past(ld_val))));

    assert_step_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ld_en) |=> (state != $past(state)));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !ld_en) |=> $stable(state));

endmodule

// File: rtl/weak_rom_read.sv
module weak_rom_read
    import wbr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned RAND_BITS = 3,
    parameter int unsigned WIN_SIZE  = 128,
    parameter logic [DATA_W-1:0] PATTERN = 8'hF2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] rom_data,
    input  logic [31:0]       seed_in,
    input  logic              st_load,
    input  logic [31:0]       st_load_val,
    output logic [31:0]       st_out,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned NUM_WIN = 2;

    logic        prot_hit;
    prng_state_t cur_state;

    wbr_window_match #(
        .ADDR_W  (ADDR_W),
        .NUM_WIN (NUM_WIN),
        .WIN_SIZE(WIN_SIZE),
        .WIN_BASE({16'hFE80, 16'hCE80})
    ) u_match (
        .addr(cpu_addr),
        .hit (prot_hit)
    );

    wbr_prng_state u_prng (
        .clk   (clk),
        .rst_n (rst_n),
        .seed  (seed_in),
        .adv   (rd_en && prot_hit),
        .ld_en (st_load),
        .ld_val(st_load_val),
        .state (cur_state)
    );

    always_comb begin
        if (prot_hit) begin
            rd_data = {PATTERN[DATA_W-1:RAND_BITS], cur_state[RAND_BITS-1:0]};
        end else begin
            rd_data = rom_data;
        end
    end

    assign st_out = cur_state;

    assert_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_hit |-> (rd_data == rom_data));

    assert_pattern_R3: assert property (@(posedge clk) disable iff (!rst_n)
        prot_hit |-> (rd_data[DATA_W-1:RAND_BITS] == PATTERN[DATA_W-1:RAND_BITS]
                      && rd_data[RAND_BITS-1:0] == st_out[RAND_BITS-1:0]));

    assert_no_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !st_load) |=> $stable(st_out));

endmodule

// File: tb/weak_rom_read_test.sv
`timescale 1ns/1ps
module weak_rom_read_test;

    localparam logic [31:0] ZSUB = 32'h1D87_2B41;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rom_data = '0;
    logic [31:0] seed_in = 32'h1234_5678;
    logic        st_load = 1'b0;
    logic [31:0] st_load_val = '0;
    logic [31:0] st_out;
    logic [7:0]  rd_data;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    weak_rom_read uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .rd_en(rd_en),
        .rom_data(rom_data), .seed_in(seed_in), .st_load(st_load),
        .st_load_val(st_load_val), .st_out(st_out), .rd_data(rd_data)
    );

    function automatic logic [31:0] ref_step(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    function automatic bit in_win(input logic [15:0] a);
        return (a >= 16'hCE80 && a <= 16'hCEFF) || (a >= 16'hFE80 && a <= 16'hFEFF);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // advance one clock; inputs already set after a negedge; sample after next negedge
    task automatic tick();
        @(negedge clk);
        #0.5;
    endtask

    logic [31:0] model;
    logic [7:0]  saved_seq [5];

    initial begin
        // reset with nonzero seed: R6
        repeat (3) @(negedge clk);
        #0.5;
        check("R6 seed", st_out, 32'h1234_5678);
        @(negedge clk);
        rst_n = 1'b1;
        model = 32'h1234_5678;
        #0.5;

        // full address sweep with strobe: R1 R2 R3 R4 R5
        for (int a = 0; a < 65536; a++) begin
            cpu_addr = a[15:0];
            rom_data = a[7:0] ^ a[15:8] ^ 8'h5A;
            rd_en = 1'b1;
            #0.5;
            if (in_win(a[15:0]))
                check((a[15:8] == 8'hCE) ? "R1 R3 win0" : "R2 R3 win1",
                      {24'd0, rd_data}, {24'd0, 5'b11110, model[2:0]});
            else
                check((a == 16'hCE7F || a == 16'hCF00 || a == 16'hFE7F) ? "R1 R2 edge" : "R4 pass",
                      {24'd0, rd_data}, {24'd0, rom_data});
            tick();
            if (in_win(a[15:0])) model = ref_step(model);
            if ((a & 16'h0FFF) == 16'h0FFF) check("R4 R5 state", st_out, model);
        end
        check("R5 after sweep", st_out, model);

        // strobe low inside window: R9
        rd_en = 1'b0;
        cpu_addr = 16'hCE80;
        repeat (4) tick();
        check("R9 hold", st_out, model);
        check("R9 pattern", {24'd0, rd_data}, {24'd0, 5'b11110, model[2:0]});

        // single step: R5
        rd_en = 1'b1;
        cpu_addr = 16'hFEFF;
        tick();
        rd_en = 1'b0;
        model = ref_step(model);
        check("R5 step", st_out, model);

        // load: R7
        st_load = 1'b1;
        st_load_val = 32'hDEAD_BEEF;
        tick();
        check("R7 load", st_out, 32'hDEAD_BEEF);
        st_load_val = 32'h0;
        tick();
        check("R7 zero load", st_out, ZSUB);
        st_load = 1'b0;

        // collision: R8
        rd_en = 1'b1;
        cpu_addr = 16'hFEC0;
        st_load = 1'b1;
        st_load_val = 32'h0BAD_F00D;
        tick();
        check("R8 load wins", st_out, 32'h0BAD_F00D);
        st_load_val = 32'h0;
        tick();
        check("R8 zero load wins", st_out, ZSUB);
        st_load = 1'b0;
        rd_en = 1'b0;

        // save, run, restore, rerun: R7
        model = st_out;
        cpu_addr = 16'hCEA0;
        for (int i = 0; i < 5; i++) begin
            rd_en = 1'b1;
            #0.5;
            saved_seq[i] = rd_data;
            tick();
        end
        rd_en = 1'b0;
        st_load = 1'b1;
        st_load_val = model;
        tick();
        st_load = 1'b0;
        check("R7 restore", st_out, model);
        for (int i = 0; i < 5; i++) begin
            rd_en = 1'b1;
            #0.5;
            check("R7 replay", {24'd0, rd_data}, {24'd0, saved_seq[i]});
            tick();
        end
        rd_en = 1'b0;

        // reset with zero seed: R6
        seed_in = 32'h0;
        rst_n = 1'b0;
        #1;
        check("R6 zero seed", st_out, ZSUB);
        @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        check("R6 after release", st_out, ZSUB);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule